// File: doc/BRIEF.md
# Watchdog Timer with Keyed Feed and Shadowed Control

This block is a watchdog timer for a small controller. A free-running oscillator-period tick first passes a fixed divider, then a power-of-two prescaler, and then an 8-bit down counter. If software does not service the watchdog in time, the counter expires. The block then raises a sticky timeout flag and, in reset mode, pulses a one-clock reset request to the chip's reset controller.

The control byte is guarded. Software writes it through a byte-wide register write bus, but the write only lands in a shadow copy. The active settings (prescaler select, low-voltage and oscillator-fail reset enables, run and mode) pick up the shadow value only when a keyed two-write feed completes: 0xA5 to the first key address and then 0x5A to the second. The same feed reloads the down counter from the reload register and clears the divider and the prescaler. The block leaves reset already running. With the default parameters its first timeout comes 98304 oscillator periods after reset (12 × 32 × 256). Stopping the watchdog takes a feed that carries a cleared run bit.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the outputs show the running state: `wdt_run`=1, `lvr_en`=1, `ofr_en`=0, `wdt_tof`=0, `wdt_rst`=0. The first reset pulse follows after DIV × 2^(3+PRE_BASE) × 256 oscillator ticks.
- R2: A write to address 0 (control) changes none of `lvr_en`, `ofr_en` or `wdt_run` until a valid feed. The control byte layout is: bits 7:5 prescaler select, bit 4 low-voltage reset enable, bit 3 oscillator-fail reset enable, bit 2 run, bit 1 timeout flag, bit 0 mode.
- R3: A valid feed is 0xA5 written to address 2 with the very next bus write being 0x5A to address 3. Idle cycles between the two writes are allowed. A valid feed copies the shadow control fields into the active settings.
- R4: Any other bus write between the key bytes, a wrong second byte, or a second byte written alone does not feed. The sequence must restart with 0xA5.
- R5: A valid feed loads the down counter from the reload register (address 1) and clears the divider and prescaler. The next timeout comes after DIV × 2^(PRE+PRE_BASE) × (reload+1) ticks.
- R6: On expiry while running, `wdt_tof` is set and, with mode bit = 1, `wdt_rst` is high for exactly one clock. The counter reloads and keeps counting, so expiries repeat at the same interval.
- R7: With mode bit = 0, expiry sets `wdt_tof` but `wdt_rst` stays low.
- R8: With the run bit cleared through a feed, the counter stops. No flag and no reset pulse follow.
- R9: A control write with bit 1 = 0 clears `wdt_tof` in the next cycle. A write with bit 1 = 1 leaves it unchanged. A simultaneous expiry wins over the clear.
- R10: While `osc_tick` is low the timer makes no progress and `wdt_rst` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Clock enable, one pulse per oscillator period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | 0 control, 1 reload, 2 first key, 3 second key |
| bus_wdata | input | 8 | Write data byte |
| wdt_rst | output | 1 | One-clock reset request on timeout |
| wdt_tof | output | 1 | Sticky timeout flag |
| lvr_en | output | 1 | Active low-voltage reset enable |
| ofr_en | output | 1 | Active oscillator-fail reset enable |
| wdt_run | output | 1 | Active run setting |

## Verification
The bench builds the block with DIV=2 and PRE_BASE=0. This shrinks the reset-time timeout to 4096 ticks, so the full power-up interval runs to completion instead of being taken on trust. With a reload of 3 and prescaler select 0, a timeout takes only 8 ticks. That makes the exact tick count of each expiry, back-to-back expiries, the flag-only mode and the stopped state each checkable in a few dozen cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_RELOAD = 2'd1,
    ADDR_KEY1   = 2'd2,
    ADDR_KEY2   = 2'd3
  } wdt_addr_e;

  localparam logic [7:0] KEY_FIRST  = 8'hA5;
  localparam logic [7:0] KEY_SECOND = 8'h5A;

  // Settings that pass through the shadow; the flag bit is handled apart.
  typedef struct packed {
    logic [2:0] pre;
    logic       lvr_en;
    logic       ofr_en;
    logic       run;
    logic       mode;
  } wdt_cfg_t;

  localparam wdt_cfg_t CFG_RST = '{pre: 3'd3, lvr_en: 1'b1, ofr_en: 1'b0,
                                   run: 1'b1, mode: 1'b1};

  function automatic wdt_cfg_t byte_to_cfg(input logic [7:0] b);
    wdt_cfg_t c;
    c.pre    = b[7:5];
    c.lvr_en = b[4];
    c.ofr_en = b[3];
    c.run    = b[2];
    c.mode   = b[0];
    return c;
  endfunction

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic       feed_ok
);

  logic armed_q;
  logic key1_hit;

  assign key1_hit = (bus_addr == ADDR_KEY1) && (bus_wdata == KEY_FIRST);
  assign feed_ok  = armed_q && bus_wr && (bus_addr == ADDR_KEY2) &&
                    (bus_wdata == KEY_SECOND);

  // Every bus write either arms (first key) or disarms the sequence.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (bus_wr) armed_q <= key1_hit;
  end

endmodule

// File: rtl/wdt_tick_chain.sv
module wdt_tick_chain #(
  parameter int DIV      = 12,
  parameter int PRE_BITS = 3,
  parameter int PRE_BASE = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                osc_tick,
  input  logic                run,
  input  logic                clear,
  input  logic [PRE_BITS-1:0] pre_sel,
  output logic                step
);

  localparam int PSC_W = PRE_BASE + (1 << PRE_BITS);

  logic div_evt;

  generate
    if (DIV > 1) begin : g_div
      localparam int DIV_W = $clog2(DIV);
      logic [DIV_W-1:0] div_q;
      assign div_evt = osc_tick && run && (div_q == DIV_W'(DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                div_q <= '0;
        else if (clear)            div_q <= '0;
        else if (div_evt)          div_q <= '0;
        else if (osc_tick && run)  div_q <= div_q + 1'b1;
      end
    end else begin : g_nodiv
      assign div_evt = osc_tick && run;
    end
  endgenerate

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] psc_last;

  always_comb begin
    psc_last = PSC_W'((64'd1 << (int'(pre_sel) + PRE_BASE)) - 64'd1);
  end

  assign step = !clear && div_evt && (psc_q == psc_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       psc_q <= '0;
    else if (clear)   psc_q <= '0;
    else if (step)    psc_q <= '0;
    else if (div_evt) psc_q <= psc_q + 1'b1;
  end

endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt #(
  parameter int               CNT_W      = 8,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic             run,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  // A feed (load) takes priority over an expiry in the same cycle.
  assign expire = !load && run && step && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= RELOAD_RST;
    else if (load)          cnt_q <= load_val;
    else if (expire)        cnt_q <= load_val;
    else if (run && step)   cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int               DIV        = 12,
  parameter int               PRE_BASE   = 2,
  parameter int               CNT_W      = 8,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic       wdt_rst,
  output logic       wdt_tof,
  output logic       lvr_en,
  output logic       ofr_en,
  output logic       wdt_run
);

  localparam int PRE_BITS = 3;

  wdt_cfg_t         shadow_q;
  wdt_cfg_t         act_q;
  logic [CNT_W-1:0] reload_q;
  logic             tof_q;
  logic             rst_q;
  logic             feed_ok;
  logic             step;
  logic             expire;
  logic             ctrl_wr;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);

  wdt_key_seq u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .feed_ok   (feed_ok)
  );

  wdt_tick_chain #(
    .DIV      (DIV),
    .PRE_BITS (PRE_BITS),
    .PRE_BASE (PRE_BASE)
  ) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .run      (act_q.run),
    .clear    (feed_ok),
    .pre_sel  (act_q.pre),
    .step     (step)
  );

  wdt_down_cnt #(
    .CNT_W      (CNT_W),
    .RELOAD_RST (RELOAD_RST)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (feed_ok),
    .load_val (reload_q),
    .step     (step),
    .run      (act_q.run),
    .expire   (expire)
  );

  // Shadow and reload registers take bus writes directly.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= CFG_RST;
      reload_q <= RELOAD_RST;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_CTRL)   shadow_q <= byte_to_cfg(bus_wdata);
      if (bus_addr == ADDR_RELOAD) reload_q <= CNT_W'(bus_wdata);
    end
  end

  // Active settings move only on a completed key sequence.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       act_q <= CFG_RST;
    else if (feed_ok) act_q <= shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tof_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= expire && act_q.mode;
      if (expire)                       tof_q <= 1'b1;
      else if (ctrl_wr && !bus_wdata[1]) tof_q <= 1'b0;
    end
  end

  assign wdt_rst = rst_q;
  assign wdt_tof = tof_q;
  assign lvr_en  = act_q.lvr_en;
  assign ofr_en  = act_q.ofr_en;
  assign wdt_run = act_q.run;

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_tick,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       wdt_rst,
  input logic       wdt_tof,
  input logic       lvr_en,
  input logic       ofr_en,
  input logic       wdt_run,
  input logic       feed_ok,
  input logic       expire,
  input logic       act_mode,
  input logic       act_run
);

  p_shadow_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !feed_ok |=> $stable({lvr_en, ofr_en, wdt_run}));

  p_rst_one_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  p_rst_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> wdt_tof);

  p_rst_needs_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> $past(act_mode));

  p_rst_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> $past(act_run));

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && !bus_wdata[1] && !expire) |=> !wdt_tof);

  p_no_tick_no_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> !wdt_rst);

endmodule

bind wdt_keyed wdt_keyed_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .osc_tick  (osc_tick),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .wdt_rst   (wdt_rst),
  .wdt_tof   (wdt_tof),
  .lvr_en    (lvr_en),
  .ofr_en    (ofr_en),
  .wdt_run   (wdt_run),
  .feed_ok   (feed_ok),
  .expire    (expire),
  .act_mode  (act_q.mode),
  .act_run   (act_q.run)
);

// File: tb/wdt_keyed_tb.sv
`timescale 1ns/1ps
module wdt_keyed_tb;

  localparam int TB_DIV  = 2;
  localparam int TB_BASE = 0;
  localparam int T_RESET = TB_DIV * (1 << (3 + TB_BASE)) * 256;
  localparam int T_SHORT = TB_DIV * (1 << (0 + TB_BASE)) * 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       wdt_rst, wdt_tof, lvr_en, ofr_en, wdt_run;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  wdt_keyed #(.DIV(TB_DIV), .PRE_BASE(TB_BASE)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .wdt_rst   (wdt_rst),
    .wdt_tof   (wdt_tof),
    .lvr_en    (lvr_en),
    .ofr_en    (ofr_en),
    .wdt_run   (wdt_run)
  );

  // {addr, data, expected {lvr_en, ofr_en, wdt_run}} after the write
  localparam logic [12:0] VEC [12] = '{
    {2'd0, 8'h65, 3'b101},   // R2 shadow only
    {2'd2, 8'hA5, 3'b101},   // R3 first key
    {2'd3, 8'h5A, 3'b001},   // R3 feed applies
    {2'd0, 8'h7D, 3'b001},   // R2 shadow only
    {2'd2, 8'hA5, 3'b001},   // R4 arm
    {2'd1, 8'h10, 3'b001},   // R4 foreign write aborts
    {2'd3, 8'h5A, 3'b001},   // R4 no feed
    {2'd2, 8'hA5, 3'b001},   // R4 arm
    {2'd3, 8'h5B, 3'b001},   // R4 wrong byte
    {2'd3, 8'h5A, 3'b001},   // R4 second key alone
    {2'd2, 8'hA5, 3'b001},   // R3 arm
    {2'd3, 8'h5A, 3'b111}    // R3 feed applies
  };

  function automatic string vec_req(input int i);
    if (i == 0 || i == 3) return "R2";
    if (i >= 4 && i <= 9) return "R4";
    return "R3";
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic feed();
    bus_write(2'd2, 8'hA5);
    bus_write(2'd3, 8'h5A);
  endtask

  // Run ticks until the chosen output rises or max edges pass.
  task automatic measure(input int max, input bit on_flag, output int n, output bit saw_rst);
    @(negedge clk);
    osc_tick = 1'b1;
    n = 0; saw_rst = 1'b0;
    while (n < max) begin
      @(posedge clk);
      n++;
      #1;
      if (wdt_rst) saw_rst = 1'b1;
      if (on_flag ? wdt_tof : wdt_rst) break;
    end
    osc_tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int  n;
    bit  saw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(wdt_run == 1'b1, "R1 run", wdt_run, 1);
    chk(lvr_en  == 1'b1, "R1 lvr_en", lvr_en, 1);
    chk(ofr_en  == 1'b0, "R1 ofr_en", ofr_en, 0);
    chk(wdt_tof == 1'b0, "R1 tof", wdt_tof, 0);
    chk(wdt_rst == 1'b0, "R1 rst", wdt_rst, 0);

    // R1 reset-time timeout
    measure(T_RESET + 20, 1'b0, n, saw);
    chk(n == T_RESET, "R1 first timeout ticks", n, T_RESET);
    chk(wdt_tof == 1'b1, "R6 flag after timeout", wdt_tof, 1);
    @(posedge clk); #1;
    chk(wdt_rst == 1'b0, "R6 reset pulse one clock", wdt_rst, 0);

    // Table walk: R2, R3, R4
    for (int i = 0; i < 12; i++) begin
      bus_write(VEC[i][12:11], VEC[i][10:3]);
      chk({lvr_en, ofr_en, wdt_run} == VEC[i][2:0], vec_req(i),
          int'({lvr_en, ofr_en, wdt_run}), int'(VEC[i][2:0]));
    end

    // R5 reload and prescaler select via feed
    bus_write(2'd1, 8'd3);
    bus_write(2'd0, 8'h05);
    feed();
    measure(100, 1'b0, n, saw);
    chk(n == T_SHORT, "R5 timeout ticks after feed", n, T_SHORT);
    chk(wdt_tof == 1'b1, "R6 flag set", wdt_tof, 1);
    @(posedge clk); #1;
    chk(wdt_rst == 1'b0, "R6 pulse width", wdt_rst, 0);
    measure(100, 1'b0, n, saw);
    chk(n == T_SHORT, "R6 repeated timeout ticks", n, T_SHORT);

    // R9 flag clear rules
    bus_write(2'd0, 8'h07);
    chk(wdt_tof == 1'b1, "R9 write of 1 keeps flag", wdt_tof, 1);
    bus_write(2'd0, 8'h05);
    chk(wdt_tof == 1'b0, "R9 write of 0 clears flag", wdt_tof, 0);

    // R10 no ticks, no progress
    saw = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      if (wdt_rst || wdt_tof) saw = 1'b1;
    end
    chk(saw == 1'b0, "R10 idle without ticks", saw, 0);
    measure(100, 1'b0, n, saw);
    chk(n == T_SHORT, "R10 count resumes intact", n, T_SHORT);
    @(posedge clk); #1;

    // R7 flag-only mode
    bus_write(2'd0, 8'h04);
    feed();
    chk(wdt_tof == 1'b0, "R7 flag cleared before run", wdt_tof, 0);
    measure(100, 1'b1, n, saw);
    chk(n == T_SHORT, "R7 flag timing", n, T_SHORT);
    chk(saw == 1'b0, "R7 no reset pulse", saw, 0);

    // R8 stopped watchdog
    bus_write(2'd0, 8'h00);
    feed();
    chk(wdt_run == 1'b0, "R8 run cleared", wdt_run, 0);
    measure(200, 1'b1, n, saw);
    chk(n == 200, "R8 no flag while stopped", n, 200);
    chk(saw == 1'b0, "R8 no reset while stopped", saw, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule